// File: doc/BRIEF.md
# Serial Carry-Save Multiply-Accumulator

This block multiplies two unsigned N-bit operands and adds the product to a running accumulator of width 2N + OVW. It uses one bit of the multiplier per clock. A single row of N AND gates and N full adders adds the current partial product to a sum word and a carry word. Each cycle the least significant sum bit is shifted into a low-word register. After N cycles the high half of the product is left in redundant form, as a sum word plus a carry word.

The redundant high word is not resolved by a wide adder. When the next operation is accepted, the sum and carry words move into a pending pair, and the low word of the accumulator reloads the sum register. A one-bit serial adder then resolves the pending pair during the next N cycles. Each resolved bit enters through the top bit of the sum register, so the conversion overlaps the next multiplication. The carry out of the last serial step has weight 2^(2N) and increments a separate overflow counter.

A flush operation is a multiply by zero. It resolves the last pending word, leaves the accumulator in plain binary and raises a one-cycle completion pulse. A clear input empties the accumulator when the unit is idle.

Top module: `smac`

## Requirements
- R1: After reset, busy_o and done_o are 0 and acc_ovf_o, acc_hi_o and acc_lo_o are all zero.
- R2: start_i, flush_i and clr_i take effect only while busy_o is 0. Pulses while busy_o is 1 are ignored and do not change the final accumulated result.
- R3: An accepted start or flush makes busy_o 1 for exactly N clock cycles, starting from the edge after the one that accepted it.
- R4: After a flush completes, {acc_ovf_o, acc_hi_o, acc_lo_o} equals the value held after the last clear, plus the sum of all products a_i*b_i accepted since, modulo 2^(2N+OVW).
- R5: done_o is 1 for exactly one cycle, the first cycle with busy_o 0 after a flush. It stays 0 after a plain multiply.
- R6: clr_i while idle zeroes all three accumulator words on the next edge. It has priority over start_i and flush_i in the same cycle.
- R7: Carries beyond bit 2N-1 increment acc_ovf_o, which wraps modulo 2^OVW.
- R8: While idle with no control input high, the accumulator outputs hold their values.
- R9: A flush with no multiply since the previous flush leaves the result unchanged.
- R10: When start_i and flush_i are both high, the request is a multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a multiply-add of a_i by b_i |
| flush_i | input | 1 | Request resolution of the pending redundant word |
| clr_i | input | 1 | Zero the accumulator |
| a_i | input | N | Multiplicand, captured on acceptance |
| b_i | input | N | Multiplier, captured on acceptance |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse at the end of a flush |
| acc_ovf_o | output | OVW | Overflow word (accumulator bits above 2N-1) |
| acc_hi_o | output | N | High accumulator word, binary after a flush |
| acc_lo_o | output | N | Low accumulator word |

## Verification
The idle-hold assertion assumes that the accumulator registers change only on a clear or an accepted request. It also assumes that the carry word stays zero during a flush, because the captured multiplier is then zero. The row-sum check assumes the four inputs of the full-adder row are settled, so it compares arithmetic sums and ignores bit patterns. The stimulus drives every control on the falling edge as a single-cycle pulse and captures operands only on acceptance. It deliberately pulses all three controls in the middle of a busy period, so the ignore rule is exercised without breaking the assumptions above. A long run of maximum-value products drives the overflow word past its wrap point.

// File: rtl/smac_pkg.sv
package smac_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} smac_st_e;
endpackage

// File: rtl/smac_csa_row.sv
module smac_csa_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic         bit_i,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] o_o
);
  for (genvar j = 0; j < W; j++) begin : g_fa
    logic pp;
    assign pp     = a_i[j] & bit_i;
    assign q_o[j] = s_i[j] ^ c_i[j] ^ pp;
    assign o_o[j] = (s_i[j] & c_i[j]) | (s_i[j] & pp) | (c_i[j] & pp);
  end

  always_comb begin
    AST_ROW_SUM: assert ({2'b0, q_o} + {1'b0, o_o, 1'b0} ==
                         {2'b0, s_i} + {2'b0, c_i} + (bit_i ? {2'b0, a_i} : '0)); // R4
  end
endmodule

// File: rtl/smac_serial_add.sv
module smac_serial_add (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic en_i,
  input  logic x_i,
  input  logic y_i,
  output logic sum_o,
  output logic cout_o
);
  logic cy_q;

  assign sum_o  = x_i ^ y_i ^ cy_q;
  assign cout_o = (x_i & y_i) | (x_i & cy_q) | (y_i & cy_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cy_q <= 1'b0;
    else if (load_i) cy_q <= 1'b0;
    else if (en_i)   cy_q <= cout_o;
  end

  AST_CARRY_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !cy_q); // R4
endmodule

// File: rtl/smac_ovf_cnt.sv
module smac_ovf_cnt #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_OVF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !clr_i |=> cnt_o == $past(cnt_o) + 1'b1); // R7
  AST_OVF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0); // R6
endmodule

// File: rtl/smac.sv
module smac #(
  parameter int N   = 16,
  parameter int OVW = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           flush_i,
  input  logic           clr_i,
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [OVW-1:0] acc_ovf_o,
  output logic [N-1:0]   acc_hi_o,
  output logic [N-1:0]   acc_lo_o
);
  import smac_pkg::*;

  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  smac_st_e     st_q;
  logic [CW-1:0] cnt_q;
  logic         flush_q, done_q;
  logic [N-1:0] a_q, b_q, s_q, c_q, lo_q, ps_q, pc_q;
  logic [N-1:0] row_q, row_o;
  logic         idle, run, last, acc_clr, acc_go, go_flush;
  logic         inj, ser_cout;

  assign idle     = (st_q == ST_IDLE);
  assign run      = (st_q == ST_RUN);
  assign last     = (cnt_q == LAST);
  assign acc_clr  = idle & clr_i;
  assign acc_go   = idle & ~clr_i & (start_i | flush_i);
  assign go_flush = flush_i & ~start_i;

  smac_csa_row #(.W(N)) u_row (
    .a_i  (a_q),
    .bit_i(b_q[0]),
    .s_i  (s_q),
    .c_i  (c_q),
    .q_o  (row_q),
    .o_o  (row_o)
  );

  // resolves the pending redundant high word, one bit per step
  smac_serial_add u_sadd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(acc_go),
    .en_i  (run),
    .x_i   (ps_q[0]),
    .y_i   (pc_q[0]),
    .sum_o (inj),
    .cout_o(ser_cout)
  );

  smac_ovf_cnt #(.W(OVW)) u_ovf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (acc_clr),
    .inc_i (run & last & ser_cout),
    .cnt_o (acc_ovf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      flush_q <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
      s_q     <= '0;
      c_q     <= '0;
      lo_q    <= '0;
      ps_q    <= '0;
      pc_q    <= '0;
    end else if (acc_clr) begin
      s_q  <= '0;
      c_q  <= '0;
      lo_q <= '0;
    end else if (acc_go) begin
      ps_q    <= s_q;
      pc_q    <= c_q;
      s_q     <= lo_q;
      c_q     <= '0;
      a_q     <= go_flush ? '0 : a_i;
      b_q     <= go_flush ? '0 : b_i;
      cnt_q   <= '0;
      flush_q <= go_flush;
      st_q    <= ST_RUN;
    end else if (run) begin
      s_q   <= {inj, row_q[N-1:1]};
      c_q   <= row_o;
      lo_q  <= {row_q[0], lo_q[N-1:1]};
      b_q   <= b_q >> 1;
      ps_q  <= ps_q >> 1;
      pc_q  <= pc_q >> 1;
      cnt_q <= cnt_q + 1'b1;
      if (last) st_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= run & last & flush_q;
  end

  assign busy_o   = run;
  assign done_o   = done_q;
  assign acc_hi_o = s_q;
  assign acc_lo_o = lo_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R5
  AST_RUN_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && last |=> !busy_o); // R3
  AST_RUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !last |=> busy_o); // R3
  AST_OPND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(a_q)); // R2
  AST_FLUSH_BINARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && flush_q |-> c_q == '0); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !clr_i && !start_i && !flush_i |=>
      $stable(acc_hi_o) && $stable(acc_lo_o) && $stable(acc_ovf_o)); // R8
endmodule

// File: tb/tb_smac.sv
`timescale 1ns/1ps
module tb_smac;
  localparam int N   = 16;
  localparam int OVW = 10;
  localparam int AW  = 2 * N + OVW;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, flush_i = 0, clr_i = 0;
  logic [N-1:0] a_i = '0, b_i = '0;
  logic busy_o, done_o;
  logic [OVW-1:0] acc_ovf_o;
  logic [N-1:0] acc_hi_o, acc_lo_o;

  int checks = 0, errors = 0;
  logic [AW-1:0] ref_acc = '0;

  always #2.5 clk_i = ~clk_i;

  smac #(.N(N), .OVW(OVW)) dut (.*);

  // {a, b, flush}
  localparam logic [2*N:0] VEC [10] = '{
    {16'h0003, 16'h0005, 1'b0}, {16'h0000, 16'h0000, 1'b1},
    {16'hffff, 16'hffff, 1'b0}, {16'hffff, 16'hffff, 1'b0},
    {16'h0000, 16'h0000, 1'b1}, {16'h8001, 16'h0000, 1'b0},
    {16'h1234, 16'habcd, 1'b0}, {16'h0001, 16'h0001, 1'b0},
    {16'hfedc, 16'h8000, 1'b0}, {16'h0000, 16'h0000, 1'b1}
  };

  function automatic logic [AW-1:0] acc_val();
    return {acc_ovf_o, acc_hi_o, acc_lo_o};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input bit fl);
    int n = 0;
    @(negedge clk_i);
    a_i = a; b_i = b; start_i = !fl; flush_i = fl;
    @(negedge clk_i);
    start_i = 0; flush_i = 0;
    while (busy_o && n < N + 8) begin n++; @(negedge clk_i); end
    chk(n == N, "R3 busy length", n, N);
    chk(done_o == fl, "R5 done after op", done_o, fl);
    if (!fl) ref_acc = ref_acc + AW'(a) * AW'(b);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual expired expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] snap;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o, "R1 control idle", {busy_o, done_o}, 0);
    chk(acc_val() == '0, "R1 acc zero", acc_val(), 0);
    rst_ni = 1'b1;

    // R4: table walk
    for (int i = 0; i < 10; i++) begin
      run_op(VEC[i][2*N:N+1], VEC[i][N:1], VEC[i][0]);
      if (VEC[i][0]) chk(acc_val() == ref_acc, "R4 accumulated result", acc_val(), ref_acc);
    end
    @(negedge clk_i);
    chk(done_o == 0, "R5 single pulse", done_o, 0);

    // R8: hold while idle
    snap = acc_val();
    repeat (5) @(negedge clk_i);
    chk(acc_val() == snap, "R8 idle hold", acc_val(), snap);

    // R9: repeated flush
    run_op('0, '0, 1'b1);
    chk(acc_val() == ref_acc, "R9 second flush", acc_val(), ref_acc);

    // R10: start and flush together means multiply
    @(negedge clk_i);
    a_i = 16'h0101; b_i = 16'h0202; start_i = 1; flush_i = 1;
    @(negedge clk_i);
    start_i = 0; flush_i = 0;
    while (busy_o) @(negedge clk_i);
    chk(done_o == 0, "R10 treated as multiply", done_o, 0);
    ref_acc = ref_acc + AW'(16'h0101) * AW'(16'h0202);
    run_op('0, '0, 1'b1);
    chk(acc_val() == ref_acc, "R10 product added", acc_val(), ref_acc);

    // R2: controls ignored while busy
    @(negedge clk_i);
    a_i = 16'h0033; b_i = 16'h0055; start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    repeat (3) @(negedge clk_i);
    a_i = 16'h7777; b_i = 16'h9999; start_i = 1; flush_i = 1; clr_i = 1;
    @(negedge clk_i);
    start_i = 0; flush_i = 0; clr_i = 0;
    while (busy_o) @(negedge clk_i);
    ref_acc = ref_acc + AW'(16'h0033) * AW'(16'h0055);
    run_op('0, '0, 1'b1);
    chk(acc_val() == ref_acc, "R2 busy pulses ignored", acc_val(), ref_acc);

    // R6: clear wins over start
    @(negedge clk_i);
    clr_i = 1; start_i = 1; a_i = 16'h00ff; b_i = 16'h00ff;
    @(negedge clk_i);
    clr_i = 0; start_i = 0;
    chk(!busy_o, "R6 start suppressed", busy_o, 0);
    chk(acc_val() == '0, "R6 cleared", acc_val(), 0);
    ref_acc = '0;

    // R7: overflow word wraps
    for (int k = 0; k < 1030; k++) run_op(16'hffff, 16'hffff, 1'b0);
    run_op('0, '0, 1'b1);
    chk(acc_val() == ref_acc, "R7 overflow wrap", acc_val(), ref_acc);
    chk(acc_ovf_o == ref_acc[AW-1:2*N], "R7 overflow word", acc_ovf_o, ref_acc[AW-1:2*N]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule